// File: doc/BRIEF.md
# Watchdog and Interval Timer

This block divides the main clock down to one of eight selectable interval lengths and uses each elapse in one of two ways. In interval mode it latches a maskable interrupt request every interval for as long as it runs. In watchdog mode each elapse instead produces a one-cycle overflow pulse, and software keeps that pulse from firing by restarting the count in time. Once software selects watchdog mode, only a reset brings the block back to interval mode.

The count is split into two stages. The low prescaler stage runs freely from reset and is never cleared by software. The upper stage is cleared by a RUN write, which also starts counting. Because of this split, the first interval after a RUN write can be shorter than nominal by up to one prescaler period less one cycle. Later intervals are exact. A STOP power-mode input freezes both stages, while a HALT input leaves counting untouched.

The interrupt controller owns the mask and priority flags and drives them into the block. The block gates its request with the mask and tags it with the priority. The CPU clears the latched request with an acknowledge pulse.

Top module: `wdt_interval_timer`

## Requirements
- R1: After reset the configuration reads 0x08 (watchdog bit 4 = 0, interval-enable bit 3 = 1, select bits [2:0] = 0). The counter is stopped, and irq_o and wdt_ovf_o stay low until a RUN write.
- R2: With select value s in 0..6 the steady interval is 2^(LO_EXP+s) clock cycles. Select value 7 gives 2^(LO_EXP+8). No select gives 2^(LO_EXP+7).
- R3: With bit 4 = 0 and bit 3 = 1 (interval mode), the interrupt flag is set again at every elapsed interval for as long as counting runs, and wdt_ovf_o stays low.
- R4: Writing 1 to bit 5 (RUN) clears the upper count and starts counting. The first elapse comes between 2^E-2^PRE_BITS+1 and 2^E cycles after the write edge, where 2^E is the selected interval.
- R5: While irq_mask_i is high, irq_o is held low but the flag is still latched. Releasing the mask exposes the pending request. An irq_ack_i pulse clears the flag.
- R6: irq_prio_o follows irq_prio_i while irq_o is high, and is low otherwise.
- R7: Once bit 4 is written 1, it reads 1 after every later write, including writes of 0, until reset.
- R8: In watchdog mode each elapse drives wdt_ovf_o high for exactly one cycle, and irq_o stays low.
- R9: In watchdog mode, RUN writes spaced closer than the first-interval minimum keep wdt_ovf_o low.
- R10: Every cycle with stop_i high lengthens the current interval by one cycle. halt_i has no effect on the interval.
- R11: With bit 4 = 0 and bit 3 = 0, elapses raise neither irq_o nor wdt_ovf_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | CFG_W (6) | Write data: [2:0] select, [3] interval enable, [4] watchdog, [5] RUN |
| cfg_rdata_o | output | CFG_W (6) | Read-back of the configuration; RUN reads 0 |
| halt_i | input | 1 | HALT power mode marker |
| stop_i | input | 1 | STOP power mode marker; freezes counting |
| irq_mask_i | input | 1 | Interrupt mask flag |
| irq_prio_i | input | 1 | Interrupt priority flag |
| irq_ack_i | input | 1 | Clears the latched interrupt flag |
| irq_o | output | 1 | Masked interval interrupt request |
| irq_prio_o | output | 1 | Priority tag of the visible request |
| wdt_ovf_o | output | 1 | One-cycle watchdog overflow pulse |

## Verification
The bench builds the block with LO_EXP = 4 and PRE_BITS = 2. This shrinks the intervals to 16 through 4096 cycles, so all eight selects, including the one that skips a power of two, can be swept with both a first and a steady interval measured. The small prescaler makes the short first interval span only four possible lengths. Those four lengths are checked as a range, while steady intervals and the exact cycle cost of STOP are checked to the cycle. The watchdog lock, service and pulse width are exercised last, because only reset can undo the lock.

// File: rtl/wdt_pkg.sv
// Package: shared widths, field positions, mode and power-state types.
// Assumes: configuration word of CFG_W bits with the layout given below.
package wdt_pkg;

    localparam int CFG_W    = 6;
    localparam int SEL_W    = 3;
    localparam int NUM_SEL  = 1 << SEL_W;
    localparam int BIT_IEN  = 3;
    localparam int BIT_WD   = 4;
    localparam int BIT_RUN  = 5;

    typedef enum logic [1:0] {
        PWR_RUN  = 2'd0,
        PWR_HALT = 2'd1,
        PWR_STOP = 2'd2
    } pwr_e;

    typedef enum logic [1:0] {
        MODE_IDLE     = 2'd0,
        MODE_INTERVAL = 2'd1,
        MODE_WATCH    = 2'd2
    } mode_e;

    // Extra power of two added to the base exponent for a select value;
    // the top select skips one step.
    function automatic int unsigned sel_step(input int unsigned s);
        return (s == NUM_SEL - 1) ? NUM_SEL : s;
    endfunction

    // Decode the power-mode markers; STOP dominates HALT.
    function automatic pwr_e pwr_decode(input logic halt, input logic stop);
        if (stop)      return PWR_STOP;
        else if (halt) return PWR_HALT;
        else           return PWR_RUN;
    endfunction

endpackage

// File: rtl/wdt_prescaler.sv
// Free-running low prescaler stage.
// Counts every enabled cycle from reset and is never cleared by software.
// Assumes PRE_BITS >= 1. tick_o marks the enabled cycle in which the stage wraps.
module wdt_prescaler #(
    parameter int PRE_BITS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cnt_en_i,
    output logic tick_o
);

    logic [PRE_BITS-1:0] pre_q;

    // Advance the prescaler on every enabled cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)        pre_q <= '0;
        else if (cnt_en_i) pre_q <= pre_q + 1'b1;
    end

    // A tick marks the wrap of the stage.
    always_comb tick_o = cnt_en_i && (&pre_q);

endmodule

// File: rtl/wdt_mode_reg.sv
// Configuration register: interval select, interval enable, sticky watchdog bit.
// The RUN bit is not stored; a write with RUN set yields a one-cycle clear pulse.
// Assumes the field layout from wdt_pkg.
module wdt_mode_reg
    import wdt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we_i,
    input  logic [CFG_W-1:0]     wdata_i,
    output logic [CFG_W-1:0]     rdata_o,
    output logic [SEL_W-1:0]     sel_o,
    output mode_e                mode_o,
    output logic                 run_clr_o
);

    logic [SEL_W-1:0] sel_q;
    logic             ien_q;
    logic             wd_q;

    // Capture writes; the watchdog bit can only be set, never cleared.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
            ien_q <= 1'b1;
            wd_q  <= 1'b0;
        end else if (we_i) begin
            sel_q <= wdata_i[SEL_W-1:0];
            ien_q <= wdata_i[BIT_IEN];
            wd_q  <= wd_q | wdata_i[BIT_WD];
        end
    end

    // Decode the operating mode; the watchdog bit overrides interval enable.
    always_comb begin
        if (wd_q)       mode_o = MODE_WATCH;
        else if (ien_q) mode_o = MODE_INTERVAL;
        else            mode_o = MODE_IDLE;
    end

    // Clear pulse and read-back composition.
    always_comb begin
        run_clr_o        = we_i && wdata_i[BIT_RUN];
        sel_o            = sel_q;
        rdata_o          = '0;
        rdata_o[SEL_W-1:0] = sel_q;
        rdata_o[BIT_IEN] = ien_q;
        rdata_o[BIT_WD]  = wd_q;
    end

endmodule

// File: rtl/wdt_interval_ctr.sv
// Upper counter stage with interval selection.
// Counts prescaler ticks, wraps at the selected length and flags the elapse.
// Assumes LO_EXP > PRE_BITS, so the shortest interval spans at least two ticks.
module wdt_interval_ctr
    import wdt_pkg::*;
#(
    parameter int LO_EXP   = 12,
    parameter int PRE_BITS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_clr_i,
    input  logic             tick_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             elapse_o
);

    localparam int CNT_W = LO_EXP + NUM_SEL - PRE_BITS;

    logic [CNT_W-1:0] cnt_q;
    logic             running_q;
    logic [CNT_W-1:0] last_tbl [NUM_SEL];
    logic             at_last;

    // Terminal count for every select value, built per entry.
    for (genvar g = 0; g < NUM_SEL; g++) begin : g_last
        localparam int SH = LO_EXP - PRE_BITS + int'(sel_step(g));
        assign last_tbl[g] = {CNT_W{1'b1}} >> (CNT_W - SH);
    end

    // Reaching or passing the terminal count ends the interval.
    always_comb at_last = (cnt_q >= last_tbl[sel_i]);

    // Clear and start on RUN; otherwise count ticks and wrap at the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            running_q <= 1'b0;
        end else if (run_clr_i) begin
            cnt_q     <= '0;
            running_q <= 1'b1;
        end else if (running_q && tick_i) begin
            cnt_q     <= at_last ? '0 : cnt_q + 1'b1;
        end
    end

    // An elapse is the final tick of an interval that was not cleared this cycle.
    always_comb elapse_o = running_q && tick_i && at_last && !run_clr_i;

endmodule

// File: rtl/wdt_event_out.sv
// Turns elapses into the masked interrupt request or the overflow pulse.
// Assumes elapse_i is a single-cycle strobe.
module wdt_event_out
    import wdt_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  elapse_i,
    input  mode_e mode_i,
    input  logic  mask_i,
    input  logic  prio_i,
    input  logic  ack_i,
    output logic  irq_o,
    output logic  irq_prio_o,
    output logic  ovf_o
);

    logic flag_q;
    logic ovf_q;

    // Latch the interval request; a new elapse wins over an acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)                                    flag_q <= 1'b0;
        else if (elapse_i && mode_i == MODE_INTERVAL)  flag_q <= 1'b1;
        else if (ack_i)                                flag_q <= 1'b0;
    end

    // Register a one-cycle overflow pulse for each watchdog elapse.
    always_ff @(posedge clk) begin
        if (!rst_n) ovf_q <= 1'b0;
        else        ovf_q <= elapse_i && (mode_i == MODE_WATCH);
    end

    // Expose the request only in interval mode and when unmasked.
    always_comb begin
        irq_o      = flag_q && !mask_i && (mode_i == MODE_INTERVAL);
        irq_prio_o = irq_o && prio_i;
        ovf_o      = ovf_q;
    end

endmodule

// File: rtl/wdt_interval_timer.sv
// Top: watchdog / interval timer built from a free-running prescaler,
// a selectable upper counter, a configuration register and the event stage.
// Assumes a single clock domain with synchronous active-low reset.
module wdt_interval_timer
    import wdt_pkg::*;
#(
    parameter int LO_EXP   = 12,
    parameter int PRE_BITS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we_i,
    input  logic [CFG_W-1:0] cfg_wdata_i,
    output logic [CFG_W-1:0] cfg_rdata_o,
    input  logic             halt_i,
    input  logic             stop_i,
    input  logic             irq_mask_i,
    input  logic             irq_prio_i,
    input  logic             irq_ack_i,
    output logic             irq_o,
    output logic             irq_prio_o,
    output logic             wdt_ovf_o
);

    pwr_e             pwr_state;
    logic             cnt_en;
    logic             tick;
    logic             run_clr;
    logic             elapse;
    logic [SEL_W-1:0] sel;
    mode_e            mode;

    // Counting is frozen only in STOP; HALT keeps the clock chain alive.
    always_comb begin
        pwr_state = pwr_decode(halt_i, stop_i);
        cnt_en    = (pwr_state != PWR_STOP);
    end

    wdt_mode_reg u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_i      (cfg_we_i),
        .wdata_i   (cfg_wdata_i),
        .rdata_o   (cfg_rdata_o),
        .sel_o     (sel),
        .mode_o    (mode),
        .run_clr_o (run_clr)
    );

    wdt_prescaler #(.PRE_BITS(PRE_BITS)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_en_i (cnt_en),
        .tick_o   (tick)
    );

    wdt_interval_ctr #(.LO_EXP(LO_EXP), .PRE_BITS(PRE_BITS)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_clr_i (run_clr),
        .tick_i    (tick),
        .sel_i     (sel),
        .elapse_o  (elapse)
    );

    wdt_event_out u_evt (
        .clk        (clk),
        .rst_n      (rst_n),
        .elapse_i   (elapse),
        .mode_i     (mode),
        .mask_i     (irq_mask_i),
        .prio_i     (irq_prio_i),
        .ack_i      (irq_ack_i),
        .irq_o      (irq_o),
        .irq_prio_o (irq_prio_o),
        .ovf_o      (wdt_ovf_o)
    );

endmodule

// File: rtl/wdt_interval_timer_chk.sv
// Checker for wdt_interval_timer, attached with bind below.
// Observes top-level ports only.
module wdt_interval_timer_chk
    import wdt_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [CFG_W-1:0] cfg_rdata_o,
    input logic             stop_i,
    input logic             irq_mask_i,
    input logic             irq_prio_i,
    input logic             irq_o,
    input logic             irq_prio_o,
    input logic             wdt_ovf_o
);

    assert_wd_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata_o[BIT_WD] |=> cfg_rdata_o[BIT_WD]);

    assert_ovf_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_ovf_o |=> !wdt_ovf_o);

    assert_ovf_needs_watch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_ovf_o |-> $past(cfg_rdata_o[BIT_WD]));

    assert_no_irq_in_watch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata_o[BIT_WD] |-> !irq_o);

    assert_mask_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_mask_i |-> !irq_o);

    assert_prio_tag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_prio_o |-> (irq_o && irq_prio_i));

    assert_stop_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_ovf_o |-> !$past(stop_i));

endmodule

bind wdt_interval_timer wdt_interval_timer_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_rdata_o (cfg_rdata_o),
    .stop_i      (stop_i),
    .irq_mask_i  (irq_mask_i),
    .irq_prio_i  (irq_prio_i),
    .irq_o       (irq_o),
    .irq_prio_o  (irq_prio_o),
    .wdt_ovf_o   (wdt_ovf_o)
);

// File: tb/wdt_interval_timer_tb.sv
// Bench: sweeps all selects in a scaled-down build and checks timing arithmetically.
module wdt_interval_timer_tb;

    localparam int LO_EXP   = 4;
    localparam int PRE_BITS = 2;
    localparam int PRE_LEN  = 1 << PRE_BITS;
    localparam int WDOG     = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we_i = 1'b0;
    logic [5:0] cfg_wdata_i = '0;
    logic [5:0] cfg_rdata_o;
    logic       halt_i = 1'b0;
    logic       stop_i = 1'b0;
    logic       irq_mask_i = 1'b0;
    logic       irq_prio_i = 1'b0;
    logic       irq_ack_i = 1'b0;
    logic       irq_o;
    logic       irq_prio_o;
    logic       wdt_ovf_o;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int ovf_seen = 0;
    int irq_seen = 0;

    always #2 clk = ~clk;

    wdt_interval_timer #(.LO_EXP(LO_EXP), .PRE_BITS(PRE_BITS)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we_i(cfg_we_i), .cfg_wdata_i(cfg_wdata_i),
        .cfg_rdata_o(cfg_rdata_o), .halt_i(halt_i), .stop_i(stop_i),
        .irq_mask_i(irq_mask_i), .irq_prio_i(irq_prio_i), .irq_ack_i(irq_ack_i),
        .irq_o(irq_o), .irq_prio_o(irq_prio_o), .wdt_ovf_o(wdt_ovf_o)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (wdt_ovf_o) ovf_seen++;
        if (irq_o)     irq_seen++;
    end

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc > WDOG) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run hung, actual cycle %0d expected below %0d", cyc, WDOG);
            finish_run();
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Bench-side interval length for a select value.
    function automatic int interval_len(input int s);
        return 1 << (LO_EXP + ((s == 7) ? 8 : s));
    endfunction

    // One-edge configuration write; returns the edge count of the write.
    task automatic cfg_write(input logic [5:0] v, output int t);
        cfg_wdata_i = v;
        cfg_we_i    = 1'b1;
        @(negedge clk);
        t           = cyc;
        cfg_we_i    = 1'b0;
        cfg_wdata_i = '0;
    endtask

    task automatic wait_irq(output int t);
        while (!irq_o) @(negedge clk);
        t = cyc;
    endtask

    task automatic wait_ovf(output int t);
        while (!wdt_ovf_o) @(negedge clk);
        t = cyc;
    endtask

    task automatic ack_irq();
        irq_ack_i = 1'b1;
        @(negedge clk);
        irq_ack_i = 1'b0;
    endtask

    initial begin
        int tw, t1, t2, len, base;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state and idle outputs before any RUN write
        check(cfg_rdata_o == 6'h08, "R1 reset config", cfg_rdata_o, 8);
        repeat (300) @(negedge clk);
        check(irq_seen == 0 && ovf_seen == 0, "R1 no events before RUN", irq_seen + ovf_seen, 0);

        // R2/R3/R4: sweep every select in interval mode
        for (int s = 0; s < 8; s++) begin
            len = interval_len(s);
            cfg_write(6'h28 | 6'(s), tw);
            check(cfg_rdata_o == (6'h08 | 6'(s)), "R2 select readback", cfg_rdata_o, 8 + s);
            wait_irq(t1);
            check((t1 - tw) <= len && (t1 - tw) > len - PRE_LEN,
                  "R4 first interval", t1 - tw, len);
            ack_irq();
            check(irq_o == 1'b0, "R5 ack clears request", irq_o, 0);
            wait_irq(t2);
            check((t2 - t1) == len, "R2 steady interval", t2 - t1, len);
            ack_irq();
            wait_irq(t1);
            check((t1 - t2) == len, "R3 repeated request", t1 - t2, len);
            ack_irq();
        end
        check(ovf_seen == 0, "R3 no overflow in interval mode", ovf_seen, 0);

        // R10: STOP adds one cycle per stopped edge, HALT adds none
        cfg_write(6'h28, tw);
        wait_irq(t1);
        irq_ack_i = 1'b1;
        @(negedge clk);
        irq_ack_i = 1'b0;
        stop_i    = 1'b1;
        repeat (10) @(negedge clk);
        stop_i = 1'b0;
        wait_irq(t2);
        check((t2 - t1) == 16 + 10, "R10 stop freezes count", t2 - t1, 26);
        irq_ack_i = 1'b1;
        @(negedge clk);
        irq_ack_i = 1'b0;
        halt_i    = 1'b1;
        repeat (10) @(negedge clk);
        halt_i = 1'b0;
        wait_irq(t1);
        check((t1 - t2) == 16, "R10 halt keeps counting", t1 - t2, 16);
        ack_irq();

        // R5: masked request is latched and shown once unmasked
        irq_mask_i = 1'b1;
        base = irq_seen;
        repeat (40) @(negedge clk);
        check(irq_seen == base, "R5 mask holds irq low", irq_seen - base, 0);
        irq_mask_i = 1'b0;
        #1;
        check(irq_o == 1'b1, "R5 pending shown on unmask", irq_o, 1);

        // R6: priority tag follows the flag while a request is visible
        irq_prio_i = 1'b1;
        #1;
        check(irq_prio_o == 1'b1, "R6 priority tag high", irq_prio_o, 1);
        irq_prio_i = 1'b0;
        #1;
        check(irq_prio_o == 1'b0, "R6 priority tag low", irq_prio_o, 0);
        irq_prio_i = 1'b1;
        @(negedge clk);
        ack_irq();
        #1;
        check(irq_prio_o == 1'b0, "R6 no tag without request", irq_prio_o, 0);
        irq_prio_i = 1'b0;

        // R11: both mode bits clear raises nothing
        cfg_write(6'h20, tw);
        base = irq_seen;
        repeat (100) @(negedge clk);
        check(irq_seen == base && ovf_seen == 0, "R11 idle mode silent", irq_seen - base, 0);
        check(cfg_rdata_o == 6'h00, "R11 idle readback", cfg_rdata_o, 0);

        // R8: watchdog mode gives single-cycle overflow pulses
        cfg_write(6'h30, tw);
        check(cfg_rdata_o == 6'h10, "R7 watchdog set", cfg_rdata_o, 16);
        base = irq_seen;
        wait_ovf(t1);
        check((t1 - tw) <= 16 && (t1 - tw) > 16 - PRE_LEN, "R8 first overflow", t1 - tw, 16);
        @(negedge clk);
        check(wdt_ovf_o == 1'b0, "R8 overflow is one cycle", wdt_ovf_o, 0);
        wait_ovf(t2);
        check((t2 - t1) == 16, "R8 overflow period", t2 - t1, 16);
        check(irq_seen == base, "R8 no irq in watchdog", irq_seen - base, 0);

        // R9: servicing with RUN keeps overflow away
        @(negedge clk);
        base = ovf_seen;
        for (int k = 0; k < 12; k++) begin
            cfg_write(6'h30, tw);
            repeat (8) @(negedge clk);
        end
        check(ovf_seen == base, "R9 service prevents overflow", ovf_seen - base, 0);

        // R7: writing 0 to the watchdog bit leaves it set
        cfg_write(6'h08, tw);
        check(cfg_rdata_o == 6'h18, "R7 watchdog lock", cfg_rdata_o, 24);
        base = irq_seen;
        repeat (60) @(negedge clk);
        check(irq_seen == base, "R8 irq stays low after lock", irq_seen - base, 0);
        check(ovf_seen > base - base, "R7 watchdog still overflows", ovf_seen, 1);

        finish_run();
    end

endmodule